// File: doc/BRIEF.md
# Seconds Counter with Match Alarm

This block keeps a 32-bit count of elapsed seconds. Software reaches it through a small word-addressed register bus with an APB-style select/enable/write handshake and a 4 KB address window. A one-cycle strobe, supplied from outside once per second, advances the count. Software may preload the count, program a match value, and enable or disable the interrupt. It can also read the raw and the gated alarm status and acknowledge the alarm. A fixed set of identification bytes appears near the top of the window, one byte in the low bits of each word.

The alarm is an exact-equality compare between the count and the match value. Both wrap modulo 2^32, so a match value below the current count fires after the counter rolls over. Any event that changes the count or the match value is compared in the same cycle. This means a match write or a count preload that produces equality raises the alarm at once, without waiting for a tick. The interrupt line is level-sensitive. It stays high while the alarm is latched and the enable bit is set.

Top module: `secs_alarm_top`

## Requirements
- R1: After synchronous active-low reset, the count, match, load readback, interrupt-enable and raw-status registers read 0, and `irq` is 0.
- R2: Each clock cycle with `tick_1hz` high and no load write increments the count by one, modulo 2^32. The count holds in every other cycle. Offset 0x00 reads the live count.
- R3: A write to offset 0x08 makes the written value the new count, and this takes priority over a tick in the same cycle. Offset 0x08 reads back the last value written to it.
- R4: Offset 0x04 holds the match value and reads it back. The raw status (bit 0 of offset 0x14) is set in the cycle where a tick makes the count equal the match value, including after the count wraps from 0xFFFFFFFF to 0.
- R5: A match write or a load write that leaves the count equal to the match value sets the raw status in that same cycle.
- R6: Offset 0x10 keeps only bit 0 of a write as the interrupt enable. Offset 0x18 reads raw status AND enable, and `irq` equals the same value.
- R7: A write of any data to offset 0x1C clears the raw status. A set event in the same cycle wins, so the status stays 1.
- R8: Offset 0x0C always reads 1, and writes to it change nothing.
- R9: Word offsets 0xFE0, 0xFE4 ... 0xFFC read the bytes 0x31, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1, in that order of rising address, in bits 7:0 with zero upper bits.
- R10: Writes to offsets 0x00, 0x14 and 0x18 have no effect. Reads of 0x1C, of any other unmapped offset and of non-word-aligned offsets return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_1hz | input | 1 | One-cycle strobe, once per second |
| psel | input | 1 | Register bus select |
| penable | input | 1 | Register bus access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte offset within the 4 KB window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, combinational from the address |
| irq | output | 1 | Level interrupt, raw status AND enable |

## Verification
The bench builds the block with its default 32-bit data width. This keeps the full modulo-2^32 rollover within reach: the count is preloaded just below 0xFFFFFFFF, so the wrap-through-zero alarm takes only two ticks. The bench also places a tick and a status clear in the same cycle, and a tick and a preload in the same cycle, so that the priority rules are observed at the ports.

// File: rtl/secs_alarm_pkg.sv
package secs_alarm_pkg;
  localparam int unsigned ADDR_W = 12;

  localparam logic [ADDR_W-1:0] OFF_COUNT  = 12'h000;
  localparam logic [ADDR_W-1:0] OFF_MATCH  = 12'h004;
  localparam logic [ADDR_W-1:0] OFF_LOAD   = 12'h008;
  localparam logic [ADDR_W-1:0] OFF_CTRL   = 12'h00C;
  localparam logic [ADDR_W-1:0] OFF_ENABLE = 12'h010;
  localparam logic [ADDR_W-1:0] OFF_RAW    = 12'h014;
  localparam logic [ADDR_W-1:0] OFF_GATED  = 12'h018;
  localparam logic [ADDR_W-1:0] OFF_ACK    = 12'h01C;

  // upper seven address bits of the identification area
  localparam logic [6:0] ID_AREA = 7'h7F;

  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    case (idx)
      3'd0:    return 8'h31;
      3'd1:    return 8'h10;
      3'd2:    return 8'h14;
      3'd3:    return 8'h00;
      3'd4:    return 8'h0D;
      3'd5:    return 8'hF0;
      3'd6:    return 8'h05;
      default: return 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/secs_alarm_counter.sv
module secs_alarm_counter #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              load_we,
  input  logic              match_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] count,
  output logic [DATA_W-1:0] match,
  output logic              hit
);
  localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

  function automatic logic [DATA_W-1:0] next_sec(input logic [DATA_W-1:0] c);
    return c + ONE;
  endfunction

  logic [DATA_W-1:0] count_q, count_d, match_q, match_d;
  logic              evt;

  always_comb begin
    if (load_we)   count_d = wdata;
    else if (tick) count_d = next_sec(count_q);
    else           count_d = count_q;
    match_d = match_we ? wdata : match_q;
    evt     = load_we | match_we | tick;
    hit     = evt && (count_d == match_d);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
      match_q <= '0;
    end else begin
      count_q <= count_d;
      match_q <= match_d;
    end
  end

  assign count = count_q;
  assign match = match_q;

  assert_tick_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load_we) |=> (count == $past(count) + ONE));

  assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load_we) |=> $stable(count));

  assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load_we |=> (count == $past(wdata)));

  assert_match_wr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    match_we |=> (match == $past(wdata)));
endmodule

// File: rtl/secs_alarm_irq.sv
module secs_alarm_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic ack_we,
  input  logic enable_we,
  input  logic enable_d,
  output logic raw,
  output logic enable,
  output logic irq
);
  logic raw_q, en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_q <= 1'b0;
      en_q  <= 1'b0;
    end else begin
      if (hit)         raw_q <= 1'b1;
      else if (ack_we) raw_q <= 1'b0;
      if (enable_we)   en_q  <= enable_d;
    end
  end

  assign raw    = raw_q;
  assign enable = en_q;
  assign irq    = raw_q & en_q;

  assert_alarm_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> raw);

  assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_we && !hit) |=> !raw);

  assert_raw_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_we && !hit) |=> $stable(raw));

  assert_enable_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_we |=> $stable(enable));
endmodule

// File: rtl/secs_alarm_regs.sv
module secs_alarm_regs
  import secs_alarm_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  input  logic [DATA_W-1:0] count,
  input  logic [DATA_W-1:0] match,
  input  logic              raw,
  input  logic              enable,
  output logic              load_we,
  output logic              match_we,
  output logic              enable_we,
  output logic              ack_we,
  output logic [DATA_W-1:0] prdata
);
  localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

  logic              wr_acc;
  logic [DATA_W-1:0] load_q;

  assign wr_acc    = psel & penable & pwrite;
  assign load_we   = wr_acc && (paddr == OFF_LOAD);
  assign match_we  = wr_acc && (paddr == OFF_MATCH);
  assign enable_we = wr_acc && (paddr == OFF_ENABLE);
  assign ack_we    = wr_acc && (paddr == OFF_ACK);

  always_ff @(posedge clk) begin
    if (!rst_n)       load_q <= '0;
    else if (load_we) load_q <= pwdata;
  end

  always_comb begin
    prdata = '0;
    case (paddr)
      OFF_COUNT:  prdata = count;
      OFF_MATCH:  prdata = match;
      OFF_LOAD:   prdata = load_q;
      OFF_CTRL:   prdata = ONE;
      OFF_ENABLE: prdata = {{(DATA_W-1){1'b0}}, enable};
      OFF_RAW:    prdata = {{(DATA_W-1){1'b0}}, raw};
      OFF_GATED:  prdata = {{(DATA_W-1){1'b0}}, raw & enable};
      default: begin
        if (paddr[ADDR_W-1:5] == ID_AREA && paddr[1:0] == 2'b00)
          prdata = {{(DATA_W-8){1'b0}}, id_byte(paddr[4:2])};
      end
    endcase
  end

  assert_one_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({load_we, match_we, enable_we, ack_we}) <= 1);

  assert_load_rb_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !load_we |=> $stable(load_q));
endmodule

// File: rtl/secs_alarm_top.sv
module secs_alarm_top
  import secs_alarm_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1hz,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [11:0]       paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              irq
);
  logic              load_we, match_we, enable_we, ack_we;
  logic [DATA_W-1:0] count, match;
  logic              hit, raw, enable;

  secs_alarm_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata),
    .count(count), .match(match), .raw(raw), .enable(enable),
    .load_we(load_we), .match_we(match_we),
    .enable_we(enable_we), .ack_we(ack_we),
    .prdata(prdata)
  );

  secs_alarm_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick_1hz),
    .load_we(load_we), .match_we(match_we), .wdata(pwdata),
    .count(count), .match(match), .hit(hit)
  );

  secs_alarm_irq u_irq (
    .clk(clk), .rst_n(rst_n), .hit(hit), .ack_we(ack_we),
    .enable_we(enable_we), .enable_d(pwdata[0]),
    .raw(raw), .enable(enable), .irq(irq)
  );

  assert_irq_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !irq);

  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(!rst_n) |-> (!irq && count == '0));
endmodule

// File: tb/secs_alarm_top_tb_top.sv
module secs_alarm_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_1hz = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    bit          is_irq;
    logic [11:0] addr;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t exp_q[$];
  event  sample_ev;

  always #(CLK_PERIOD/2) clk = ~clk;

  secs_alarm_top dut_i (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz),
    .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq(irq)
  );

  // monitor: pops the expected item and compares it with the port value
  always @(sample_ev) begin
    item_t it;
    logic [31:0] act;
    it  = exp_q.pop_front();
    act = it.is_irq ? {31'd0, irq} : prdata;
    checks++;
    if (act !== it.exp) begin
      fails++;
      $display("FAIL %s addr=0x%03h actual=0x%08h expected=0x%08h",
               it.tag, it.addr, act, it.exp);
    end
  end

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d, input bit tk = 0);
    @(negedge clk);
    psel = 1; penable = 1; pwrite = 1; paddr = a; pwdata = d; tick_1hz = tk;
    @(negedge clk);
    psel = 0; penable = 0; pwrite = 0; tick_1hz = 0;
  endtask

  task automatic tick_once();
    @(negedge clk); tick_1hz = 1;
    @(negedge clk); tick_1hz = 0;
  endtask

  task automatic expect_rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    psel = 1; penable = 1; pwrite = 0; paddr = a;
    it.is_irq = 0; it.addr = a; it.exp = e; it.tag = tag;
    exp_q.push_back(it);
    #(CLK_PERIOD/4);
    -> sample_ev;
    @(negedge clk);
    psel = 0; penable = 0;
  endtask

  task automatic expect_irq(input bit e, input string tag);
    item_t it;
    @(negedge clk);
    it.is_irq = 1; it.addr = '0; it.exp = {31'd0, e}; it.tag = tag;
    exp_q.push_back(it);
    #(CLK_PERIOD/4);
    -> sample_ev;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 50000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    expect_rd(12'h000, 32'd0, "R1 count");
    expect_rd(12'h004, 32'd0, "R1 match");
    expect_rd(12'h008, 32'd0, "R1 load");
    expect_rd(12'h010, 32'd0, "R1 enable");
    expect_rd(12'h014, 32'd0, "R1 raw");
    expect_irq(0, "R1 irq");

    // R8 control
    expect_rd(12'h00C, 32'd1, "R8 ctrl");
    bus_write(12'h00C, 32'h0);
    expect_rd(12'h00C, 32'd1, "R8 ctrl after write");

    // R2 ticks (match is 0, count 1..3: no alarm)
    for (int i = 0; i < 3; i++) tick_once();
    expect_rd(12'h000, 32'd3, "R2 count after 3 ticks");
    expect_rd(12'h014, 32'd0, "R2 raw idle");

    // R3 load
    bus_write(12'h008, 32'd100);
    expect_rd(12'h000, 32'd100, "R3 count loaded");
    expect_rd(12'h008, 32'd100, "R3 load readback");

    // R10 write to count ignored
    bus_write(12'h000, 32'd5);
    expect_rd(12'h000, 32'd100, "R10 count write ignored");

    // R4 alarm by tick
    bus_write(12'h004, 32'd102);
    expect_rd(12'h004, 32'd102, "R4 match readback");
    tick_once();
    expect_rd(12'h014, 32'd0, "R4 raw before match");
    tick_once();
    expect_rd(12'h014, 32'd1, "R4 raw at match");
    expect_irq(0, "R6 irq disabled");
    expect_rd(12'h018, 32'd0, "R6 gated disabled");

    // R6 enable keeps bit 0
    bus_write(12'h010, 32'hFFFF_FFFE);
    expect_rd(12'h010, 32'd0, "R6 enable bit0 only");
    bus_write(12'h010, 32'd3);
    expect_rd(12'h010, 32'd1, "R6 enable set");
    expect_irq(1, "R6 irq on");
    expect_rd(12'h018, 32'd1, "R6 gated on");

    // R10 writes to status offsets ignored
    bus_write(12'h014, 32'd0);
    expect_rd(12'h014, 32'd1, "R10 raw write ignored");
    bus_write(12'h018, 32'd0);
    expect_rd(12'h014, 32'd1, "R10 gated write ignored");

    // R7 clear on any data
    bus_write(12'h01C, 32'd0);
    expect_rd(12'h014, 32'd0, "R7 raw cleared");
    expect_irq(0, "R7 irq cleared");

    // R5 immediate on match write (count is 102)
    bus_write(12'h004, 32'd102);
    expect_rd(12'h014, 32'd1, "R5 match write equal");
    bus_write(12'h01C, 32'h1234);
    bus_write(12'h004, 32'd7);
    expect_rd(12'h014, 32'd0, "R5 no fire unequal");
    bus_write(12'h008, 32'd7);
    expect_rd(12'h014, 32'd1, "R5 load equal");
    bus_write(12'h01C, 32'd0);

    // R4 wrap
    bus_write(12'h008, 32'hFFFF_FFFE);
    bus_write(12'h004, 32'd0);
    tick_once();
    expect_rd(12'h000, 32'hFFFF_FFFF, "R2 near wrap");
    expect_rd(12'h014, 32'd0, "R4 raw before wrap");
    tick_once();
    expect_rd(12'h000, 32'd0, "R2 wrapped");
    expect_rd(12'h014, 32'd1, "R4 raw after wrap");
    bus_write(12'h01C, 32'd0);

    // R7 set wins over clear in the same cycle
    bus_write(12'h008, 32'd10);
    bus_write(12'h004, 32'd11);
    bus_write(12'h01C, 32'd0, 1);
    expect_rd(12'h000, 32'd11, "R7 tick with clear");
    expect_rd(12'h014, 32'd1, "R7 set wins");
    bus_write(12'h01C, 32'd0);
    expect_rd(12'h014, 32'd0, "R7 later clear");

    // R3 load beats tick
    bus_write(12'h008, 32'd50, 1);
    expect_rd(12'h000, 32'd50, "R3 load over tick");

    // R9 identification bytes
    expect_rd(12'hFE0, 32'h31, "R9 id0");
    expect_rd(12'hFE4, 32'h10, "R9 id1");
    expect_rd(12'hFE8, 32'h14, "R9 id2");
    expect_rd(12'hFEC, 32'h00, "R9 id3");
    expect_rd(12'hFF0, 32'h0D, "R9 id4");
    expect_rd(12'hFF4, 32'hF0, "R9 id5");
    expect_rd(12'hFF8, 32'h05, "R9 id6");
    expect_rd(12'hFFC, 32'hB1, "R9 id7");

    // R10 unmapped reads
    expect_rd(12'h01C, 32'd0, "R10 ack read");
    expect_rd(12'h020, 32'd0, "R10 unmapped");
    expect_rd(12'h800, 32'd0, "R10 unmapped mid");
    expect_rd(12'hFE1, 32'd0, "R10 unaligned id");

    // R1 reset again
    bus_write(12'h010, 32'd1);
    bus_write(12'h004, 32'd50);
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    expect_rd(12'h000, 32'd0, "R1 count after reset");
    expect_rd(12'h008, 32'd0, "R1 load after reset");
    expect_rd(12'h014, 32'd0, "R1 raw after reset");
    expect_rd(12'h010, 32'd0, "R1 enable after reset");

    repeat (2) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule